// File: doc/BRIEF.md
# Ping-Pong Buffer Descriptor Engine

This block holds the transfer descriptors for a set of DMA channels, each of which is double-buffered. Every channel owns two descriptor slots. A slot records whether a buffer is armed (ready), whether its transfer has finished (done), whether that transfer failed (error), whether the buffer opens a packet (packet-start), the buffer length minus one, and a 32-bit buffer address. Software arms buffers with a start command. The data mover, which is outside this block, reports completions by strobing a channel. Software then releases finished slots with a service command.

Each channel walks its slots strictly in the order 0, 1, 0, 1 with three independent pointers. The start pointer picks the slot to arm, the active pointer picks the slot a completion retires, and the service pointer picks the slot to release. A completion raises the channel's status bit. Status bits are cleared by writing ones. The interrupt output is active while any status bit is set together with its mask bit. A channel holds at most two buffers, so a start aimed at an occupied slot is refused.

A read port returns the packed flag word and both address words of one selected channel.

Top module: `ppd_engine`

## Requirements
- R1: After reset every slot of every channel reads all-zero flags and a zero address, all status and mask bits are 0, irq is 0, and every pointer selects slot 0.
- R2: An accepted start on a channel arms the slot chosen by that channel's start pointer. It sets ready, copies start_pkt into packet-start and start_size (the buffer length minus one) into the size field, clears done and error, and stores start_addr in that slot's address word. The start pointer then toggles, so successive starts use slots 0, 1, 0, 1.
- R3: rd_flags carries slot 0 in bits 15:0 and slot 1 in bits 31:16. Within each 16-bit half, bits 11:0 are the size, bit 12 is error, bit 13 is done, bit 14 is packet-start and bit 15 is ready. rd_addr0 and rd_addr1 are the address words of slots 0 and 1.
- R4: A start whose target slot still has ready or done set is an overflow. In that same cycle start_rej is 1, and the channel's slots and pointers are left unchanged. start_rej is 0 in every cycle without such a start.
- R5: A completion strobe on a channel whose active slot is ready clears ready, sets done, loads error from cmpl_err, sets the channel's status bit and toggles the active pointer. A completion on a channel whose active slot is not ready changes nothing.
- R6: A service command on a channel whose service-pointer slot has done set clears that slot's done, error and ready bits, keeps its size, packet-start and address, and toggles the service pointer. Otherwise the command changes nothing.
- R7: Writing 1 to a bit of sts_clr clears that status bit on the next edge. A completion on the same channel in the same cycle wins, so the bit stays 1.
- R8: mask_we loads the whole mask from mask_wdata. irq equals the OR over all channels of status AND mask, with no added delay, so clearing a mask bit silences that channel at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_vld | input | 1 | Start command strobe |
| start_ch | input | CW | Channel of the start command |
| start_pkt | input | 1 | Packet-start value for the armed slot |
| start_size | input | 12 | Buffer length minus one |
| start_addr | input | 32 | Buffer address |
| start_rej | output | 1 | Start refused: target slot occupied |
| cmpl_vld | input | 1 | Completion strobe from the data mover |
| cmpl_ch | input | CW | Channel that completed |
| cmpl_err | input | 1 | Completion ended in error |
| svc_vld | input | 1 | Service (release) command strobe |
| svc_ch | input | CW | Channel to service |
| sts_clr | input | NCH | Write-one-to-clear for status bits |
| mask_we | input | 1 | Mask write enable |
| mask_wdata | input | NCH | New mask value |
| rd_ch | input | CW | Channel selected for readback |
| rd_flags | output | 32 | Packed flag word of the selected channel |
| rd_addr0 | output | 32 | Slot 0 address of the selected channel |
| rd_addr1 | output | 32 | Slot 1 address of the selected channel |
| sts | output | NCH | Per-channel status bits |
| mask | output | NCH | Per-channel interrupt mask |
| irq | output | 1 | Masked interrupt |

## Verification
A pointer that drifts out of order shows up on the first command that follows. A start arms the wrong half of rd_flags, a completion retires the wrong slot, or start_rej fires against a free slot in the very cycle of the start. A corrupted slot flag is visible on the readback port one cycle after the command that caused it. A lost or extra status bit shows on sts and, when masked in, on irq in the cycle after the completion. Random traffic is concentrated on a few channels so that overflows, ignored completions and ignored services keep happening, and each of these outcomes is compared with a bench model after every cycle.

// File: rtl/ppd_pkg.sv
// Shared constants and slot type for the ping-pong descriptor engine.
// Assumes a 16-bit slot image: ready, packet-start, done, error, then size.
package ppd_pkg;
    localparam int SLOT_W = 16;
    localparam int SIZE_W = 12;
    localparam int ADDR_W = 32;

    // Field order from MSB down gives the readback layout directly.
    typedef struct packed {
        logic              rdy;
        logic              pkt;
        logic              done;
        logic              err;
        logic [SIZE_W-1:0] size;
    } slot_t;
endpackage

// File: rtl/ppd_chan.sv
// One channel: two descriptor slots and three toggling pointers
// (arm, retire, release). Assumes hit strobes are already decoded
// for this channel; a slot is free only when neither ready nor done.
module ppd_chan
    import ppd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_hit,
    input  logic                 start_pkt,
    input  logic [SIZE_W-1:0]    start_size,
    input  logic [ADDR_W-1:0]    start_addr,
    input  logic                 cmpl_hit,
    input  logic                 cmpl_err,
    input  logic                 svc_hit,
    output logic                 slot_free,
    output logic                 fin_evt,
    output logic [2*SLOT_W-1:0]  flags,
    output logic [ADDR_W-1:0]    addr0,
    output logic [ADDR_W-1:0]    addr1
);
    slot_t             slot_q [2];
    logic [ADDR_W-1:0] addr_q [2];
    logic              wr_p, act_p, svc_p;
    logic              take, rel;

    // Decide which command takes effect this cycle.
    always_comb begin
        slot_free = ~slot_q[wr_p].rdy & ~slot_q[wr_p].done;
        take      = start_hit & slot_free;
        fin_evt   = cmpl_hit & slot_q[act_p].rdy;
        rel       = svc_hit & slot_q[svc_p].done;
    end

    // Update slot flags; arm, retire and release act on disjoint slot states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                slot_q[i] <= '0;
                addr_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                if (take && (wr_p == i[0])) begin
                    slot_q[i].rdy  <= 1'b1;
                    slot_q[i].pkt  <= start_pkt;
                    slot_q[i].done <= 1'b0;
                    slot_q[i].err  <= 1'b0;
                    slot_q[i].size <= start_size;
                    addr_q[i]      <= start_addr;
                end
                if (fin_evt && (act_p == i[0])) begin
                    slot_q[i].rdy  <= 1'b0;
                    slot_q[i].done <= 1'b1;
                    slot_q[i].err  <= cmpl_err;
                end
                if (rel && (svc_p == i[0])) begin
                    slot_q[i].rdy  <= 1'b0;
                    slot_q[i].done <= 1'b0;
                    slot_q[i].err  <= 1'b0;
                end
            end
        end
    end

    // Advance each pointer when its command takes effect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_p  <= 1'b0;
            act_p <= 1'b0;
            svc_p <= 1'b0;
        end else begin
            wr_p  <= wr_p ^ take;
            act_p <= act_p ^ fin_evt;
            svc_p <= svc_p ^ rel;
        end
    end

    // Present the packed readback image.
    always_comb begin
        flags = {slot_q[1], slot_q[0]};
        addr0 = addr_q[0];
        addr1 = addr_q[1];
    end
endmodule

// File: rtl/ppd_irq.sv
// Status and mask registers with the combined interrupt.
// Assumes fin_vec marks channels whose completion was accepted this cycle.
module ppd_irq #(
    parameter int NCH = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] fin_vec,
    input  logic [NCH-1:0] sts_clr,
    input  logic           mask_we,
    input  logic [NCH-1:0] mask_wdata,
    output logic [NCH-1:0] sts,
    output logic [NCH-1:0] mask,
    output logic           irq
);
    // Status: write-one clears, a completion in the same cycle sets.
    always_ff @(posedge clk) begin
        if (!rst_n) sts <= '0;
        else        sts <= (sts & ~sts_clr) | fin_vec;
    end

    // Mask: whole-word load.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= mask_wdata;
    end

    // Interrupt: any unmasked pending channel.
    always_comb irq = |(sts & mask);
endmodule

// File: rtl/ppd_engine.sv
// Top of the ping-pong descriptor engine: decodes commands to channels,
// collects completions into status, and muxes one channel for readback.
// Assumes at most one start, one completion and one service per cycle.
module ppd_engine
    import ppd_pkg::*;
#(
    parameter int NCH = 32,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_vld,
    input  logic [CW-1:0]     start_ch,
    input  logic              start_pkt,
    input  logic [SIZE_W-1:0] start_size,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              start_rej,
    input  logic              cmpl_vld,
    input  logic [CW-1:0]     cmpl_ch,
    input  logic              cmpl_err,
    input  logic              svc_vld,
    input  logic [CW-1:0]     svc_ch,
    input  logic [NCH-1:0]    sts_clr,
    input  logic              mask_we,
    input  logic [NCH-1:0]    mask_wdata,
    input  logic [CW-1:0]     rd_ch,
    output logic [31:0]       rd_flags,
    output logic [ADDR_W-1:0] rd_addr0,
    output logic [ADDR_W-1:0] rd_addr1,
    output logic [NCH-1:0]    sts,
    output logic [NCH-1:0]    mask,
    output logic              irq
);
    logic [NCH-1:0]          free_vec, fin_vec;
    logic [2*SLOT_W-1:0]     flags_a [NCH];
    logic [ADDR_W-1:0]       a0_a [NCH];
    logic [ADDR_W-1:0]       a1_a [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ppd_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .start_hit  (start_vld && (start_ch == CW'(g))),
            .start_pkt  (start_pkt),
            .start_size (start_size),
            .start_addr (start_addr),
            .cmpl_hit   (cmpl_vld && (cmpl_ch == CW'(g))),
            .cmpl_err   (cmpl_err),
            .svc_hit    (svc_vld && (svc_ch == CW'(g))),
            .slot_free  (free_vec[g]),
            .fin_evt    (fin_vec[g]),
            .flags      (flags_a[g]),
            .addr0      (a0_a[g]),
            .addr1      (a1_a[g])
        );
    end

    ppd_irq #(.NCH(NCH)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fin_vec    (fin_vec),
        .sts_clr    (sts_clr),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .sts        (sts),
        .mask       (mask),
        .irq        (irq)
    );

    // Flag a start aimed at an occupied slot.
    always_comb start_rej = start_vld & ~free_vec[start_ch];

    // Readback mux for the selected channel.
    always_comb begin
        rd_flags = flags_a[rd_ch];
        rd_addr0 = a0_a[rd_ch];
        rd_addr1 = a1_a[rd_ch];
    end
endmodule

// File: rtl/ppd_chk.sv
// Port-level properties of the descriptor engine, bound to the top.
module ppd_chk #(
    parameter int NCH = 32,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_vld,
    input logic           start_rej,
    input logic           cmpl_vld,
    input logic [CW-1:0]  cmpl_ch,
    input logic [NCH-1:0] sts_clr,
    input logic           mask_we,
    input logic [31:0]    rd_flags,
    input logic [NCH-1:0] sts,
    input logic [NCH-1:0] mask,
    input logic           irq
);
    logic [NCH-1:0] cmpl_onehot;
    always_comb cmpl_onehot = cmpl_vld ? (NCH'(1) << cmpl_ch) : '0;

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_rej |-> start_vld);

    // R7
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((sts & $past(sts_clr) & ~$past(cmpl_onehot)) == '0));

    // R5
    sts_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((sts & ~$past(sts) & ~$past(cmpl_onehot)) == '0));

    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(cmpl_vld) || $past(mask_we)));

    // R8
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

    // R3
    slot_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_flags[15] && rd_flags[13]) && !(rd_flags[31] && rd_flags[29]));
endmodule

bind ppd_engine ppd_chk #(.NCH(NCH)) u_ppd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_vld (start_vld),
    .start_rej (start_rej),
    .cmpl_vld  (cmpl_vld),
    .cmpl_ch   (cmpl_ch),
    .sts_clr   (sts_clr),
    .mask_we   (mask_we),
    .rd_flags  (rd_flags),
    .sts       (sts),
    .mask      (mask),
    .irq       (irq)
);

// File: tb/test_ppd_engine.sv
module test_ppd_engine;
    localparam int NCH = 32;
    localparam int CW  = 5;
    localparam int TCK = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_vld = 0, start_pkt = 0, cmpl_vld = 0, cmpl_err = 0;
    logic            svc_vld = 0, mask_we = 0;
    logic [CW-1:0]   start_ch = 0, cmpl_ch = 0, svc_ch = 0, rd_ch = 0;
    logic [11:0]     start_size = 0;
    logic [31:0]     start_addr = 0;
    logic [NCH-1:0]  sts_clr = 0, mask_wdata = 0;
    logic            start_rej, irq;
    logic [31:0]     rd_flags, rd_addr0, rd_addr1;
    logic [NCH-1:0]  sts, mask;

    always #(TCK/2) clk = ~clk;

    ppd_engine #(.NCH(NCH)) i_ppd_engine (.*);

    // Bench model
    bit          m_rdy [NCH][2], m_pkt [NCH][2], m_dn [NCH][2], m_er [NCH][2];
    bit [11:0]   m_sz  [NCH][2];
    bit [31:0]   m_ad  [NCH][2];
    bit          m_wp [NCH], m_ap [NCH], m_sp [NCH];
    bit [NCH-1:0] m_sts, m_mask;
    int          n_chk = 0, n_bad = 0;
    bit          all_done = 0;

    function automatic bit [31:0] mflags(int c);
        return {m_rdy[c][1], m_pkt[c][1], m_dn[c][1], m_er[c][1], m_sz[c][1],
                m_rdy[c][0], m_pkt[c][0], m_dn[c][0], m_er[c][0], m_sz[c][0]};
    endfunction

    function automatic bit exp_reject();
        return start_vld && (m_rdy[start_ch][m_wp[start_ch]] || m_dn[start_ch][m_wp[start_ch]]);
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one cycle: check rejection, clock, update model, release inputs.
    task automatic tick();
        bit rj, tk, fn, rl;
        int c, w, cc, vc;
        rj = exp_reject();
        #1;
        chk(start_rej == rj, "R4 start_rej", 32'(start_rej), 32'(rj));
        tk = start_vld && !rj;
        c = start_ch; w = m_wp[c];
        cc = cmpl_ch; vc = svc_ch;
        fn = cmpl_vld && m_rdy[cc][m_ap[cc]];
        rl = svc_vld && m_dn[vc][m_sp[vc]];
        @(posedge clk);
        if (tk) begin
            m_rdy[c][w] = 1; m_pkt[c][w] = start_pkt; m_dn[c][w] = 0;
            m_er[c][w] = 0; m_sz[c][w] = start_size; m_ad[c][w] = start_addr;
            m_wp[c] = !m_wp[c];
        end
        if (fn) begin
            m_rdy[cc][m_ap[cc]] = 0; m_dn[cc][m_ap[cc]] = 1;
            m_er[cc][m_ap[cc]] = cmpl_err; m_ap[cc] = !m_ap[cc];
        end
        if (rl) begin
            m_rdy[vc][m_sp[vc]] = 0; m_dn[vc][m_sp[vc]] = 0;
            m_er[vc][m_sp[vc]] = 0; m_sp[vc] = !m_sp[vc];
        end
        m_sts = (m_sts & ~sts_clr) | (fn ? (NCH'(1) << cc) : '0);
        if (mask_we) m_mask = mask_wdata;
        @(negedge clk);
        start_vld = 0; cmpl_vld = 0; svc_vld = 0; mask_we = 0; sts_clr = '0;
    endtask

    task automatic look(int c);
        rd_ch = CW'(c);
        #1;
        chk(rd_flags == mflags(c), "R2/R5/R6 rd_flags", rd_flags, mflags(c));
        chk(rd_addr0 == m_ad[c][0], "R2 rd_addr0", rd_addr0, m_ad[c][0]);
        chk(rd_addr1 == m_ad[c][1], "R2 rd_addr1", rd_addr1, m_ad[c][1]);
        chk(sts == m_sts, "R5/R7 sts", sts, m_sts);
        chk(mask == m_mask, "R8 mask", mask, m_mask);
        chk(irq == |(m_sts & m_mask), "R8 irq", 32'(irq), 32'(|(m_sts & m_mask)));
    endtask

    task automatic do_start(int c, bit p, bit [11:0] s, bit [31:0] a);
        start_vld = 1; start_ch = CW'(c); start_pkt = p; start_size = s; start_addr = a;
        tick();
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!all_done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state on a few channels
        look(0); look(7); look(31);
        chk(rd_flags == 32'h0, "R1 flags zero", rd_flags, 32'h0);

        // R5: completion on an idle channel is ignored
        cmpl_vld = 1; cmpl_ch = 9; cmpl_err = 1; tick();
        look(9);
        chk(sts == '0, "R5 ignored completion", sts, '0);

        // R2/R3: two starts with extreme sizes and addresses
        do_start(7, 1, 12'hFFF, 32'hFFFF_FFFF);
        do_start(7, 0, 12'h000, 32'h0000_0000);
        look(7);
        chk(rd_flags == 32'h8000_CFFF, "R3 layout after starts", rd_flags, 32'h8000_CFFF);
        // R4: third start overflows, state kept
        do_start(7, 1, 12'h123, 32'h1234_5678);
        look(7);
        chk(rd_flags == 32'h8000_CFFF, "R4 no change on overflow", rd_flags, 32'h8000_CFFF);

        // R5: error completion on slot 0
        cmpl_vld = 1; cmpl_ch = 7; cmpl_err = 1; tick();
        look(7);
        chk(rd_flags == 32'h8000_7FFF, "R5 done+err slot0", rd_flags, 32'h8000_7FFF);
        chk(sts[7] == 1'b1, "R5 status set", 32'(sts[7]), 32'h1);

        // R6: service slot 0 keeps size and packet-start
        svc_vld = 1; svc_ch = 7; tick();
        look(7);
        chk(rd_flags == 32'h8000_4FFF, "R6 release slot0", rd_flags, 32'h8000_4FFF);
        // R6: service again with slot 1 not done is ignored
        svc_vld = 1; svc_ch = 7; tick();
        look(7);
        chk(rd_flags == 32'h8000_4FFF, "R6 ignored service", rd_flags, 32'h8000_4FFF);

        // R8: mask in, irq on; mask out, irq off
        mask_we = 1; mask_wdata = NCH'(1) << 7; tick();
        look(7);
        chk(irq == 1'b1, "R8 irq unmasked", 32'(irq), 32'h1);
        mask_we = 1; mask_wdata = '0; tick();
        chk(irq == 1'b0, "R8 irq masked", 32'(irq), 32'h0);

        // R7: clear collides with a new completion (slot 1): set wins
        sts_clr = NCH'(1) << 7; cmpl_vld = 1; cmpl_ch = 7; cmpl_err = 0; tick();
        look(7);
        chk(sts[7] == 1'b1, "R7 set wins", 32'(sts[7]), 32'h1);
        sts_clr = NCH'(1) << 7; tick();
        look(7);
        chk(sts[7] == 1'b0, "R7 w1c", 32'(sts[7]), 32'h0);

        // Random traffic concentrated on a few channels
        for (int k = 0; k < 4000; k++) begin
            int hot;
            hot = ($urandom % 8 == 0) ? int'($urandom % NCH) : int'($urandom % 4);
            if ($urandom % 2) begin
                start_vld = 1; start_ch = CW'(hot); start_pkt = 1'($urandom);
                start_size = 12'($urandom); start_addr = $urandom;
            end
            if ($urandom % 2) begin
                cmpl_vld = 1; cmpl_ch = CW'($urandom % 4); cmpl_err = 1'($urandom % 4 == 0);
            end
            if ($urandom % 2) begin
                svc_vld = 1; svc_ch = CW'($urandom % 4);
            end
            if ($urandom % 4 == 0) sts_clr = NCH'($urandom);
            if ($urandom % 16 == 0) begin
                mask_we = 1; mask_wdata = NCH'($urandom);
            end
            tick();
            look(int'($urandom % 4));
        end

        all_done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule